// File: doc/BRIEF.md
# Serial Start Frame Detector

This block watches a single asynchronous receive line for the header that opens a frame in an extended serial protocol. It first times a long low level (the break) against a programmable period. It then receives two control characters in standard 8N1 framing. The first character must equal a compare value. The second is accepted either by a full match or by a single selected bit. When the second character is accepted, the block emits a one-cycle pulse that marks the start of the information frame. Any failure sends the detector back to break hunting.

Three sticky event flags record break detection, the first control character matching, and the single-bit priority match. Each flag is cleared by a write-one strobe. Each flag has an interrupt output that is gated by its own enable. A status output shows whether the detector is currently hunting for a break. Baud generation is outside the block: a 16x oversample tick is supplied as an input.

Top module: `frame_start_detect`

## Requirements
- R1: After reset all three flags, all three interrupt outputs and `info_start` are 0, and `hunt_active` is 1.
- R2: The line passes through a 2-flop synchroniser (reset value 1). While hunting, `flag_brk` is set when the synchronised line has been low for `brk_len*(pre_div+1)` consecutive clocks. It becomes visible 2 clocks after the last such low sample at the pin. One clock less of low does not set it. A `brk_len` of 0 behaves as 1.
- R3: Any high sample of the synchronised line before the break period completes restarts the break timing from zero.
- R4: `hunt_active` goes to 0 in the same cycle that `flag_brk` rises from a break detection. It returns to 1 when the detector goes back to hunting.
- R5: Control characters use 8N1 framing (start 0, data LSB first, stop 1) at 16 `os_tick` per bit, sampled mid-bit, and are received only after the line has returned high following the break. If the first character has a valid stop bit and equals `cf0_cmp`, `flag_cf0` is set and the second character is awaited. Otherwise the detector returns to hunting with no flag set.
- R6: The second character is fully matched when it equals `cf1_pri` (`cf1_mode`=00), or when it equals `cf1_pri` or `cf1_sec` (any other `cf1_mode` value). Acceptance gives a single-cycle `info_start` pulse, and the detector then returns to hunting.
- R7: With `pbit_en`=1, if bit `pbit_sel` (0 = LSB) of the second character equals the same bit of `cf1_pri`, then `flag_pbit` is set and the character is accepted. `flag_pbit` and `info_start` rise in the same cycle. With `pbit_en`=0, `flag_pbit` is never set.
- R8: If the second character is neither fully matched nor priority-matched, or if its stop bit is 0, there is no `info_start` and no `flag_pbit`, and the detector returns to hunting.
- R9: A 1 on `clr_brk`, `clr_cf0` or `clr_pbit` clears only its own flag at the next edge. If a set and a clear of the same flag fall on the same edge, the set wins.
- R10: Each interrupt output equals its flag ANDed with its enable as it was one cycle earlier (`irq = flag & past(ien)`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous receive line |
| os_tick | input | 1 | 16x bit-rate oversample tick, one clock wide |
| brk_len | input | LEN_W | Break length in prescaled units |
| pre_div | input | PRE_W | Break prescaler: unit = pre_div+1 clocks |
| cf0_cmp | input | FIELD_W | Compare value for the first control character |
| cf1_pri | input | FIELD_W | Primary compare value for the second character |
| cf1_sec | input | FIELD_W | Secondary compare value for the second character |
| cf1_mode | input | 2 | 00: primary only; otherwise primary or secondary |
| pbit_en | input | 1 | Enables single-bit priority acceptance |
| pbit_sel | input | SEL_W | Bit position checked for priority |
| ien_brk | input | 1 | Interrupt enable, break |
| ien_cf0 | input | 1 | Interrupt enable, first character match |
| ien_pbit | input | 1 | Interrupt enable, priority bit |
| clr_brk | input | 1 | Write-one clear of the break flag |
| clr_cf0 | input | 1 | Write-one clear of the first-character flag |
| clr_pbit | input | 1 | Write-one clear of the priority flag |
| flag_brk | output | 1 | Break detected flag |
| flag_cf0 | output | 1 | First character matched flag |
| flag_pbit | output | 1 | Priority bit detected flag |
| irq_brk | output | 1 | Break interrupt |
| irq_cf0 | output | 1 | First character interrupt |
| irq_pbit | output | 1 | Priority interrupt |
| info_start | output | 1 | One-cycle pulse: information frame begins |
| hunt_active | output | 1 | 1 while searching for a break |

## Verification
Two pairs of events can land on the same edge. The first pair is a flag being set while software strobes its clear. The second pair is the priority flag rising together with the information-start pulse. The bench counts clocks from the falling edge at the pin to the exact edge on which the break period completes, and raises `clr_brk` for that edge alone. It then expects the flag to read 1, and to read 0 after a later lone strobe. The scoreboard records, per cycle, a vector of flag rises and `info_start`. The priority case is judged by a single vector with both bits set, not by two separate events.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_DELIM,
    ST_CF0,
    ST_CF1
  } det_state_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  localparam int NUM_FLAGS = 3;
  localparam int FL_BRK    = 0;
  localparam int FL_CF0    = 1;
  localparam int FL_PBIT   = 2;

endpackage

// File: rtl/sfd_sync.sv
module sfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b1;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/sfd_break_timer.sv
module sfd_break_timer #(
  parameter int LEN_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             line,
  input  logic [LEN_W-1:0] brk_len,
  input  logic [PRE_W-1:0] pre_div,
  output logic             hit
);
  logic [PRE_W-1:0] pre_q;
  logic [LEN_W-1:0] unit_q;
  logic             pre_wrap;
  logic             reach;

  assign pre_wrap = (pre_q == pre_div);
  // the unit now completing is the last one needed (length 0 acts as 1)
  assign reach    = ({1'b0, unit_q} + {{LEN_W{1'b0}}, 1'b1}) >= {1'b0, brk_len};
  assign hit      = en && !line && pre_wrap && reach;

  always_ff @(posedge clk) begin
    if (rst || !en || line) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else if (pre_wrap) begin
      pre_q  <= '0;
      unit_q <= reach ? unit_q : unit_q + 1'b1;
    end else begin
      pre_q  <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/sfd_char_rx.sv
module sfd_char_rx
  import sfd_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               tick,
  input  logic               line,
  output logic               valid,
  output logic [FIELD_W-1:0] data,
  output logic               stop_ok
);
  localparam int CW   = $clog2(OVS);
  localparam int IW   = (FIELD_W > 1) ? $clog2(FIELD_W) : 1;
  localparam int HALF = OVS / 2 - 1;

  rx_state_e          st_q;
  logic [CW-1:0]      cnt_q;
  logic [IW-1:0]      idx_q;
  logic [FIELD_W-1:0] shift_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shift_q <= '0;
      valid   <= 1'b0;
      data    <= '0;
      stop_ok <= 1'b0;
    end else begin
      valid <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          cnt_q <= '0;
          idx_q <= '0;
          if (!line) st_q <= RX_START;
        end
        RX_START: if (tick) begin
          if (cnt_q == CW'(HALF)) begin
            cnt_q <= '0;
            st_q  <= line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: if (tick) begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_q   <= '0;
            shift_q <= {line, shift_q[FIELD_W-1:1]};
            if (idx_q == IW'(FIELD_W - 1)) st_q <= RX_STOP;
            else                           idx_q <= idx_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_STOP: if (tick) begin
          if (cnt_q == CW'(OVS - 1)) begin
            valid   <= 1'b1;
            data    <= shift_q;
            stop_ok <= line;
            st_q    <= RX_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfd_cf1_judge.sv
module sfd_cf1_judge #(
  parameter int FIELD_W = 8,
  parameter int SEL_W   = 3
) (
  input  logic [FIELD_W-1:0] rx_byte,
  input  logic [FIELD_W-1:0] pri,
  input  logic [FIELD_W-1:0] sec,
  input  logic [1:0]         mode,
  input  logic               pb_en,
  input  logic [SEL_W-1:0]   pb_sel,
  output logic               full_hit,
  output logic               pb_hit
);
  logic [FIELD_W-1:0] eq_pri;
  logic [FIELD_W-1:0] eq_sec;

  generate
    for (genvar b = 0; b < FIELD_W; b++) begin : g_bit
      assign eq_pri[b] = (rx_byte[b] == pri[b]);
      assign eq_sec[b] = (rx_byte[b] == sec[b]);
    end
  endgenerate

  always_comb begin
    full_hit = &eq_pri;
    if (mode != 2'b00) full_hit = full_hit || (&eq_sec);
    pb_hit = 1'b0;
    if (pb_en && (32'(pb_sel) < FIELD_W)) pb_hit = eq_pri[pb_sel];
  end
endmodule

// File: rtl/frame_start_detect.sv
module frame_start_detect
  import sfd_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int PRE_W   = 4,
  parameter int FIELD_W = 8,
  parameter int SEL_W   = $clog2(FIELD_W),
  parameter int OVS     = 16,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_in,
  input  logic               os_tick,
  input  logic [LEN_W-1:0]   brk_len,
  input  logic [PRE_W-1:0]   pre_div,
  input  logic [FIELD_W-1:0] cf0_cmp,
  input  logic [FIELD_W-1:0] cf1_pri,
  input  logic [FIELD_W-1:0] cf1_sec,
  input  logic [1:0]         cf1_mode,
  input  logic               pbit_en,
  input  logic [SEL_W-1:0]   pbit_sel,
  input  logic               ien_brk,
  input  logic               ien_cf0,
  input  logic               ien_pbit,
  input  logic               clr_brk,
  input  logic               clr_cf0,
  input  logic               clr_pbit,
  output logic               flag_brk,
  output logic               flag_cf0,
  output logic               flag_pbit,
  output logic               irq_brk,
  output logic               irq_cf0,
  output logic               irq_pbit,
  output logic               info_start,
  output logic               hunt_active
);
  det_state_e st_q, st_d;
  logic               rx_s;
  logic               brk_hit;
  logic               ch_valid;
  logic [FIELD_W-1:0] ch_data;
  logic               ch_ok;
  logic               full_hit;
  logic               pb_hit;
  logic               rx_en;
  logic               good_ch;
  logic               info_d;

  logic [NUM_FLAGS-1:0] set_v, clr_v, en_v, flag_q, flag_d, irq_q;

  sfd_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d_in(rx_in), .d_out(rx_s)
  );

  sfd_break_timer #(.LEN_W(LEN_W), .PRE_W(PRE_W)) u_timer (
    .clk(clk), .rst(rst), .en(st_q == ST_HUNT), .line(rx_s),
    .brk_len(brk_len), .pre_div(pre_div), .hit(brk_hit)
  );

  assign rx_en = (st_q == ST_CF0) || (st_q == ST_CF1);

  sfd_char_rx #(.OVS(OVS), .FIELD_W(FIELD_W)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en), .tick(os_tick), .line(rx_s),
    .valid(ch_valid), .data(ch_data), .stop_ok(ch_ok)
  );

  sfd_cf1_judge #(.FIELD_W(FIELD_W), .SEL_W(SEL_W)) u_judge (
    .rx_byte(ch_data), .pri(cf1_pri), .sec(cf1_sec), .mode(cf1_mode),
    .pb_en(pbit_en), .pb_sel(pbit_sel), .full_hit(full_hit), .pb_hit(pb_hit)
  );

  assign good_ch = ch_valid && ch_ok;

  always_comb begin
    st_d   = st_q;
    info_d = 1'b0;
    set_v  = '0;
    unique case (st_q)
      ST_HUNT: if (brk_hit) begin
        st_d          = ST_DELIM;
        set_v[FL_BRK] = 1'b1;
      end
      ST_DELIM: if (rx_s) st_d = ST_CF0;
      ST_CF0: if (ch_valid) begin
        if (ch_ok && (ch_data == cf0_cmp)) begin
          st_d          = ST_CF1;
          set_v[FL_CF0] = 1'b1;
        end else begin
          st_d = ST_HUNT;
        end
      end
      ST_CF1: if (ch_valid) begin
        st_d           = ST_HUNT;
        info_d         = good_ch && (full_hit || pb_hit);
        set_v[FL_PBIT] = good_ch && pb_hit;
      end
      default: st_d = ST_HUNT;
    endcase
  end

  assign clr_v = {clr_pbit, clr_cf0, clr_brk};
  assign en_v  = {ien_pbit, ien_cf0, ien_brk};

  generate
    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      assign flag_d[f] = set_v[f] | (flag_q[f] & ~clr_v[f]);
      always_ff @(posedge clk) begin
        if (rst) begin
          flag_q[f] <= 1'b0;
          irq_q[f]  <= 1'b0;
        end else begin
          flag_q[f] <= flag_d[f];
          irq_q[f]  <= flag_d[f] & en_v[f];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_HUNT;
      info_start <= 1'b0;
    end else begin
      st_q       <= st_d;
      info_start <= info_d;
    end
  end

  assign hunt_active = (st_q == ST_HUNT);
  assign flag_brk    = flag_q[FL_BRK];
  assign flag_cf0    = flag_q[FL_CF0];
  assign flag_pbit   = flag_q[FL_PBIT];
  assign irq_brk     = irq_q[FL_BRK];
  assign irq_cf0     = irq_q[FL_CF0];
  assign irq_pbit    = irq_q[FL_PBIT];
endmodule

// File: rtl/sfd_checker.sv
module sfd_checker (
  input logic clk,
  input logic rst,
  input logic rx_s,
  input logic brk_hit,
  input logic ch_valid,
  input logic clr_brk,
  input logic ien_brk,
  input logic ien_cf0,
  input logic ien_pbit,
  input logic flag_brk,
  input logic flag_cf0,
  input logic flag_pbit,
  input logic irq_brk,
  input logic irq_cf0,
  input logic irq_pbit,
  input logic info_start,
  input logic hunt_active
);
  a_r2_brk_needs_low: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_brk) |-> $past(!rx_s));

  a_r4_hunt_drops: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_brk) |-> !hunt_active);

  a_r5_cf0_after_char: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_cf0) |-> $past(ch_valid));

  a_r6_info_single: assert property (@(posedge clk) disable iff (rst)
    info_start |=> !info_start);

  a_r7_pbit_with_info: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_pbit) |-> info_start);

  a_r9_clear_brk: assert property (@(posedge clk) disable iff (rst)
    (clr_brk && !brk_hit) |=> !flag_brk);

  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    brk_hit |=> flag_brk);

  a_r10_irq_brk: assert property (@(posedge clk) disable iff (rst)
    irq_brk == (flag_brk && $past(ien_brk)));

  a_r10_irq_cf0: assert property (@(posedge clk) disable iff (rst)
    irq_cf0 == (flag_cf0 && $past(ien_cf0)));

  a_r10_irq_pbit: assert property (@(posedge clk) disable iff (rst)
    irq_pbit == (flag_pbit && $past(ien_pbit)));
endmodule

bind frame_start_detect sfd_checker u_chk (
  .clk(clk), .rst(rst), .rx_s(rx_s), .brk_hit(brk_hit), .ch_valid(ch_valid),
  .clr_brk(clr_brk), .ien_brk(ien_brk), .ien_cf0(ien_cf0), .ien_pbit(ien_pbit),
  .flag_brk(flag_brk), .flag_cf0(flag_cf0), .flag_pbit(flag_pbit),
  .irq_brk(irq_brk), .irq_cf0(irq_cf0), .irq_pbit(irq_pbit),
  .info_start(info_start), .hunt_active(hunt_active)
);

// File: tb/frame_start_detect_tb.sv
module frame_start_detect_tb_top;
  localparam int BIT_CLK = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_in = 1'b1;
  logic os_tick = 1'b0;
  logic [15:0] brk_len = 16'd20;
  logic [3:0]  pre_div = 4'd15;
  logic [7:0]  cf0_cmp = 8'hA5, cf1_pri = 8'h5A, cf1_sec = 8'hC3;
  logic [1:0]  cf1_mode = 2'b00;
  logic        pbit_en = 1'b0;
  logic [2:0]  pbit_sel = 3'd3;
  logic ien_brk = 1'b1, ien_cf0 = 1'b1, ien_pbit = 1'b1;
  logic clr_brk = 1'b0, clr_cf0 = 1'b0, clr_pbit = 1'b0;
  logic flag_brk, flag_cf0, flag_pbit, irq_brk, irq_cf0, irq_pbit;
  logic info_start, hunt_active;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct { logic [3:0] vec; string tag; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  always @(negedge clk) os_tick <= rst ? 1'b0 : ~os_tick;

  frame_start_detect dut_i (
    .clk(clk), .rst(rst), .rx_in(rx_in), .os_tick(os_tick),
    .brk_len(brk_len), .pre_div(pre_div), .cf0_cmp(cf0_cmp),
    .cf1_pri(cf1_pri), .cf1_sec(cf1_sec), .cf1_mode(cf1_mode),
    .pbit_en(pbit_en), .pbit_sel(pbit_sel),
    .ien_brk(ien_brk), .ien_cf0(ien_cf0), .ien_pbit(ien_pbit),
    .clr_brk(clr_brk), .clr_cf0(clr_cf0), .clr_pbit(clr_pbit),
    .flag_brk(flag_brk), .flag_cf0(flag_cf0), .flag_pbit(flag_pbit),
    .irq_brk(irq_brk), .irq_cf0(irq_cf0), .irq_pbit(irq_pbit),
    .info_start(info_start), .hunt_active(hunt_active)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // vector order: {brk rise, cf0 rise, pbit rise, info_start}
  task automatic expect_ev(input logic [3:0] v, input string tag);
    exp_t e;
    e.vec = v;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: collects per-cycle events and compares with the scoreboard
  logic pb = 0, pc = 0, pp = 0;
  always @(negedge clk) begin
    logic [3:0] ev;
    if (!rst) begin
      ev = {flag_brk & ~pb, flag_cf0 & ~pc, flag_pbit & ~pp, info_start};
      if (ev != 4'b0000) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8", "unexpected event", ev, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(ev == e.vec, e.tag, "event vector", ev, e.vec);
        end
      end
    end
    pb = flag_brk; pc = flag_cf0; pp = flag_pbit;
  end

  task automatic level(input logic v, input int n);
    rx_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] b, input logic stop);
    level(1'b0, BIT_CLK);
    for (int i = 0; i < 8; i++) level(b[i], BIT_CLK);
    level(stop, BIT_CLK);
    level(1'b1, 2 * BIT_CLK);
  endtask

  task automatic clear_all(input string tag);
    clr_brk = 1; clr_cf0 = 1; clr_pbit = 1;
    @(negedge clk);
    clr_brk = 0; clr_cf0 = 0; clr_pbit = 0;
    @(negedge clk);
    check({flag_brk, flag_cf0, flag_pbit} == 3'b000, tag, "flags after clear",
          {flag_brk, flag_cf0, flag_pbit}, 0);
  endtask

  task automatic frame(input logic [7:0] c1, input logic stop1,
                       input logic [3:0] last, input string tag);
    expect_ev(4'b1000, "R2");
    level(1'b0, 400);
    level(1'b1, BIT_CLK);
    expect_ev(4'b0100, "R5");
    send_char(cf0_cmp, 1'b1);
    if (last != 4'b0000) expect_ev(last, tag);
    send_char(c1, stop1);
    check(hunt_active == 1'b1, tag, "back to hunting", hunt_active, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({flag_brk, flag_cf0, flag_pbit, irq_brk, irq_cf0, irq_pbit, info_start} == 0,
          "R1", "outputs in reset", {flag_brk, flag_cf0, flag_pbit}, 0);
    rst = 0;
    @(negedge clk);
    check(hunt_active == 1'b1, "R1", "hunt_active after reset", hunt_active, 1);

    // R2 boundary: 319 clocks low is one short
    level(1'b0, 319);
    level(1'b1, 8);
    check(flag_brk == 1'b0, "R2", "short low no break", flag_brk, 0);

    // R2 exact: 320 clocks low, flag two clocks after the last low sample
    expect_ev(4'b1000, "R2");
    level(1'b0, 320);
    rx_in = 1'b1;
    @(negedge clk);
    check(flag_brk == 1'b0, "R2", "flag one clock early", flag_brk, 0);
    @(negedge clk);
    check(flag_brk == 1'b1, "R2", "flag at exact edge", flag_brk, 1);
    check(hunt_active == 1'b0, "R4", "hunt_active dropped", hunt_active, 0);
    level(1'b1, BIT_CLK);
    send_char(8'h3C, 1'b1);
    check(hunt_active == 1'b1, "R5", "cf0 mismatch returns to hunt", hunt_active, 1);
    check(flag_cf0 == 1'b0, "R5", "no cf0 flag on mismatch", flag_cf0, 0);
    clear_all("R9");

    // R3: a single high clock restarts the timer
    level(1'b0, 200);
    level(1'b1, 1);
    level(1'b0, 200);
    level(1'b1, 8);
    check(flag_brk == 1'b0, "R3", "restart prevents break", flag_brk, 0);

    // R6 primary match, mode 00
    frame(8'h5A, 1'b1, 4'b0001, "R6");
    check(irq_brk && irq_cf0 && !irq_pbit, "R10", "irq with enables",
          {irq_brk, irq_cf0, irq_pbit}, 3'b110);
    ien_cf0 = 0;
    @(negedge clk);
    check(irq_cf0 == 1'b0 && flag_cf0 == 1'b1, "R10", "irq gated off",
          {flag_cf0, irq_cf0}, 2'b10);
    ien_cf0 = 1;
    clr_cf0 = 1;
    @(negedge clk);
    clr_cf0 = 0;
    check(flag_cf0 == 1'b0 && flag_brk == 1'b1, "R9", "clear only cf0",
          {flag_brk, flag_cf0}, 2'b10);
    clear_all("R9");

    // R6 mode 00 rejects secondary
    frame(8'hC3, 1'b1, 4'b0000, "R8");
    clear_all("R9");
    // R6 mode 01 accepts secondary
    cf1_mode = 2'b01;
    frame(8'hC3, 1'b1, 4'b0001, "R6");
    clear_all("R9");
    cf1_mode = 2'b00;

    // R7 single selected bit matches primary
    pbit_en = 1;
    frame(8'h08, 1'b1, 4'b0011, "R7");
    check(irq_pbit == 1'b1, "R10", "priority irq", irq_pbit, 1);
    clear_all("R9");
    frame(8'h5A, 1'b1, 4'b0011, "R7");
    clear_all("R9");
    frame(8'h10, 1'b1, 4'b0000, "R8");
    check(flag_pbit == 1'b0, "R8", "no pbit on bit mismatch", flag_pbit, 0);
    clear_all("R9");
    pbit_en = 0;
    frame(8'h08, 1'b1, 4'b0000, "R7");
    check(flag_pbit == 1'b0, "R7", "pbit disabled", flag_pbit, 0);
    clear_all("R9");

    // R8 framing error on second character
    frame(8'h5A, 1'b0, 4'b0000, "R8");
    clear_all("R9");

    // R9 set and clear on the same edge: set wins
    expect_ev(4'b1000, "R9");
    level(1'b0, 321);
    clr_brk = 1'b1;
    @(negedge clk);
    clr_brk = 1'b0;
    check(flag_brk == 1'b1, "R9", "set beats clear", flag_brk, 1);
    rx_in = 1'b1;
    level(1'b1, BIT_CLK);
    send_char(8'h3C, 1'b1);
    clr_brk = 1'b1;
    @(negedge clk);
    clr_brk = 1'b0;
    @(negedge clk);
    check(flag_brk == 1'b0, "R9", "lone clear", flag_brk, 0);

    // R2 length zero acts as one unit (pre_div 3 -> 4 clocks)
    brk_len = 16'd0;
    pre_div = 4'd3;
    level(1'b0, 3);
    level(1'b1, 8);
    check(flag_brk == 1'b0, "R2", "len0 three clocks", flag_brk, 0);
    expect_ev(4'b1000, "R2");
    level(1'b0, 4);
    level(1'b1, 3);
    check(flag_brk == 1'b1, "R2", "len0 four clocks", flag_brk, 1);
    send_char(8'h3C, 1'b1);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end
endmodule